// File: doc/BRIEF.md
# Single-Channel UART Register Front-End

This block is the software-visible register set of one serial channel. A host bus reads and writes byte-wide registers: line setup, channel control, status, transmit holding, receive holding and a two-byte baud divisor. Serialisation is not done here. A received byte arrives as a one-cycle strobe with its data. A byte written for transmission leaves as a one-cycle strobe with its data.

Status flags follow set and clear rules. An arriving byte sets data-ready. A transmit write sets both transmitter-empty flags. Some reads have side effects: reading status clears its low nibble, and reading the receive holding register clears data-ready. Receive and transmit interrupt requests are single-cycle pulses. Each one is gated by a two-bit mode field in the control register. The divisor is stored and returned, and nothing else uses it.

The map is: 0 line setup, 1 control, 2 status, 3 transmit holding, 4 receive holding, 5 divisor low, 6 divisor high, 7 unmapped. A read returns its data on `rd_data` in the cycle after the request. `rd_data` holds that value until the next read.

Top module: `uart_fe_regs`

## Requirements
- R1: After reset, status reads 0xC0, and every other register reads 0x00. `tx_valid`, `irq_rx` and `irq_tx` are low.
- R2: A status read (address 2) returns the current value. It then clears status bits [3:0] and leaves bits [7:4] unchanged.
- R3: An `rx_valid` strobe stores `rx_byte` in the receive holding register and sets data-ready (status bit 0). If a status read happens in the same cycle, the arrival wins and data-ready ends up set.
- R4: A read of the receive holding register (address 4) returns the stored byte. It clears status bit 0 and leaves the other status bits unchanged.
- R5: `irq_rx` pulses high for one cycle in the cycle after an `rx_valid` strobe. This happens only when control bits [1:0] equal 01.
- R6: A write to address 3 drives `tx_valid` high for one cycle in the next cycle, with the written byte on `tx_byte`. It also sets status bits 7 and 6.
- R7: `irq_tx` pulses together with `tx_valid` only when control bits [3:2] equal 11.
- R8: A read of an unmapped address (7) returns all ones. A write to it changes no register.
- R9: Line setup, control, divisor low, divisor high and transmit holding read back the last value written. A status write loads the whole status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Bus access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register select |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid the cycle after a read |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DATA_W | Received byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | DATA_W | Transmit byte |
| irq_rx | output | 1 | Receive interrupt request pulse |
| irq_tx | output | 1 | Transmit interrupt request pulse |

## Verification
The hardest case to reach is a collision between a side-effecting read and a flag being set in the same cycle. A status read that meets an arriving byte must leave data-ready set. The bench reaches this by driving a status read and an `rx_valid` strobe on the same clock edge, then reading status again. It also preloads status with a direct write so that a receive-holding read can be shown to clear only bit 0. Without that preload, the side effects of the status read would hide the result.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  localparam int SEL_W = 3;
  localparam int NSEL  = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_LINE = 3'd0,
    SEL_CTL  = 3'd1,
    SEL_STAT = 3'd2,
    SEL_TXH  = 3'd3,
    SEL_RXH  = 3'd4,
    SEL_DIVL = 3'd5,
    SEL_DIVH = 3'd6
  } reg_sel_e;

  // status bit positions
  localparam int ST_RDY  = 0;
  localparam int ST_HEMP = 6;
  localparam int ST_TEMP = 7;
  localparam logic [7:0] STAT_RESET = 8'hC0;

  // control mode encodings
  localparam logic [1:0] RX_MODE_IRQ = 2'b01;
  localparam logic [1:0] TX_MODE_IRQ = 2'b11;

endpackage

// File: rtl/uart_fe_decode.sv
module uart_fe_decode
  import uart_fe_pkg::*;
(
  input  logic             req,
  input  logic             wr,
  input  logic [SEL_W-1:0] addr,
  output logic [NSEL-1:0]  wr_sel,
  output logic [NSEL-1:0]  rd_sel
);

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign wr_sel[i] = req &  wr & (addr == SEL_W'(i));
    assign rd_sel[i] = req & ~wr & (addr == SEL_W'(i));
  end

endmodule

// File: rtl/uart_fe_status.sv
module uart_fe_status
  import uart_fe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  input  logic              rxh_rd,
  input  logic              rx_push,
  input  logic              tx_push,
  output logic [DATA_W-1:0] stat
);

  logic [DATA_W-1:0] stat_nxt;
  logic              stat_en;

  always_comb begin
    stat_nxt = stat;
    if (stat_rd) stat_nxt[3:0] = 4'h0;
    if (stat_wr) stat_nxt = wr_data;
    if (rxh_rd)  stat_nxt[ST_RDY] = 1'b0;
    if (tx_push) begin
      stat_nxt[ST_HEMP] = 1'b1;
      stat_nxt[ST_TEMP] = 1'b1;
    end
    if (rx_push) stat_nxt[ST_RDY] = 1'b1;
    stat_en = stat_rd | stat_wr | rxh_rd | tx_push | rx_push;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat <= DATA_W'(STAT_RESET);
    else if (stat_en) stat <= stat_nxt;
  end

endmodule

// File: rtl/uart_fe_irq.sv
module uart_fe_irq
  import uart_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_push,
  input  logic       tx_push,
  input  logic [1:0] rx_mode,
  input  logic [1:0] tx_mode,
  output logic       irq_rx,
  output logic       irq_tx
);

  logic irq_rx_nxt;
  logic irq_tx_nxt;

  always_comb begin
    irq_rx_nxt = rx_push & (rx_mode == RX_MODE_IRQ);
    irq_tx_nxt = tx_push & (tx_mode == TX_MODE_IRQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_rx <= 1'b0;
      irq_tx <= 1'b0;
    end else begin
      irq_rx <= irq_rx_nxt;
      irq_tx <= irq_tx_nxt;
    end
  end

endmodule

// File: rtl/uart_fe_regs.sv
module uart_fe_regs
  import uart_fe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [SEL_W-1:0]  addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_byte,
  output logic              irq_rx,
  output logic              irq_tx
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  logic [NSEL-1:0] wr_sel;
  logic [NSEL-1:0] rd_sel;

  uart_fe_decode u_dec (
    .req    (req),
    .wr     (wr),
    .addr   (addr),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  logic [DATA_W-1:0] line_q, ctl_q, txh_q, rxh_q, divl_q, divh_q;
  logic [DATA_W-1:0] stat;
  logic              tx_push;
  logic              rd_any;
  logic [DATA_W-1:0] rd_nxt;

  assign tx_push = wr_sel[SEL_TXH];
  assign rd_any  = req & ~wr;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      line_q <= '0;
      ctl_q  <= '0;
      txh_q  <= '0;
      rxh_q  <= '0;
      divl_q <= '0;
      divh_q <= '0;
    end else begin
      if (wr_sel[SEL_LINE]) line_q <= wr_data;
      if (wr_sel[SEL_CTL])  ctl_q  <= wr_data;
      if (tx_push)          txh_q  <= wr_data;
      if (rx_valid)         rxh_q  <= rx_byte;
      if (wr_sel[SEL_DIVL]) divl_q <= wr_data;
      if (wr_sel[SEL_DIVH]) divh_q <= wr_data;
    end
  end

  uart_fe_status #(.DATA_W(DATA_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .stat_wr (wr_sel[SEL_STAT]),
    .wr_data (wr_data),
    .stat_rd (rd_sel[SEL_STAT]),
    .rxh_rd  (rd_sel[SEL_RXH]),
    .rx_push (rx_valid),
    .tx_push (tx_push),
    .stat    (stat)
  );

  uart_fe_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rx_push (rx_valid),
    .tx_push (tx_push),
    .rx_mode (ctl_q[1:0]),
    .tx_mode (ctl_q[3:2]),
    .irq_rx  (irq_rx),
    .irq_tx  (irq_tx)
  );

  // read data path
  always_comb begin
    unique case (addr)
      SEL_LINE: rd_nxt = line_q;
      SEL_CTL:  rd_nxt = ctl_q;
      SEL_STAT: rd_nxt = stat;
      SEL_TXH:  rd_nxt = txh_q;
      SEL_RXH:  rd_nxt = rxh_q;
      SEL_DIVL: rd_nxt = divl_q;
      SEL_DIVH: rd_nxt = divh_q;
      default:  rd_nxt = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rd_data <= '0;
    else if (rd_any)  rd_data <= rd_nxt;
  end

  // transmit strobe
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= tx_push;
      if (tx_push) tx_byte <= wr_data;
    end
  end

endmodule

// File: rtl/uart_fe_regs_chk.sv
module uart_fe_regs_chk
  import uart_fe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req,
  input logic              wr,
  input logic [SEL_W-1:0]  addr,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              tx_valid,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic [DATA_W-1:0] stat,
  input logic [DATA_W-1:0] ctl
);

  p_stat_clr_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req && !wr && addr == SEL_STAT && !rx_valid) |=> (stat[3:0] == 4'h0));

  p_rdy_set_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_valid |=> stat[ST_RDY]);

  p_rx_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_rx |-> ($past(rx_valid) && $past(ctl[1:0]) == RX_MODE_IRQ));

  p_rx_irq_fire_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && ctl[1:0] == RX_MODE_IRQ) |=> irq_rx);

  p_tx_strobe_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req && wr && addr == SEL_TXH) |=> (tx_valid && stat[ST_HEMP] && stat[ST_TEMP]));

  p_tx_src_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_valid |-> $past(req && wr && addr == SEL_TXH));

  p_tx_irq_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_tx |-> (tx_valid && $past(ctl[3:2]) == TX_MODE_IRQ));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req && !wr && addr == 3'd7) |=> (rd_data == '1));

endmodule

bind uart_fe_regs uart_fe_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .req        (req),
  .wr         (wr),
  .addr       (addr),
  .rx_valid   (rx_valid),
  .rd_data    (rd_data),
  .tx_valid   (tx_valid),
  .irq_rx     (irq_rx),
  .irq_tx     (irq_tx),
  .stat       (stat),
  .ctl        (ctl_q)
);

// File: tb/uart_fe_regs_tb.sv
module uart_fe_regs_tb;

  logic       clk;
  logic       rst_n;
  logic       req;
  logic       wr;
  logic [2:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       irq_rx;
  logic       irq_tx;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  uart_fe_regs #(.DATA_W(8)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .wr       (wr),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .irq_rx   (irq_rx),
    .irq_tx   (irq_tx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: [23:20] requirement, [19] write, [18:16] addr, [15:8] wdata, [7:0] expected read
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, 1'b0, 3'd2, 8'h00, 8'hC0},  // R1 status reset
    {4'd1, 1'b0, 3'd1, 8'h00, 8'h00},  // R1 control reset
    {4'd1, 1'b0, 3'd4, 8'h00, 8'h00},  // R1 rx holding reset
    {4'd9, 1'b1, 3'd0, 8'h2B, 8'h00},
    {4'd9, 1'b0, 3'd0, 8'h00, 8'h2B},  // R9 line setup
    {4'd9, 1'b1, 3'd5, 8'h5A, 8'h00},
    {4'd9, 1'b1, 3'd6, 8'hA5, 8'h00},
    {4'd9, 1'b0, 3'd5, 8'h00, 8'h5A},  // R9 divisor low
    {4'd9, 1'b0, 3'd6, 8'h00, 8'hA5},  // R9 divisor high
    {4'd9, 1'b1, 3'd2, 8'hCF, 8'h00},
    {4'd9, 1'b0, 3'd2, 8'h00, 8'hCF},  // R9 status load
    {4'd2, 1'b0, 3'd2, 8'h00, 8'hC0},  // R2 low nibble cleared by read
    {4'd8, 1'b1, 3'd7, 8'h12, 8'h00},
    {4'd8, 1'b0, 3'd7, 8'h00, 8'hFF},  // R8 unmapped all ones
    {4'd8, 1'b0, 3'd0, 8'h00, 8'h2B}   // R8 write ignored
  };

  task automatic check(input int rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs registered at the edge are visible on return
  task automatic cyc(input logic rq_i, input logic wr_i, input logic [2:0] a, input logic [7:0] d,
                     input logic rxv, input logic [7:0] rxb);
    @(negedge clk);
    req = rq_i; wr = wr_i; addr = a; wr_data = d; rx_valid = rxv; rx_byte = rxb;
    @(negedge clk);
    req = 1'b0; wr = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0, 8'h00);
  endtask

  task automatic rreg(input logic [2:0] a);
    cyc(1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00);
  endtask

  task automatic rx(input logic [7:0] b);
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, b);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    req = 0; wr = 0; addr = 0; wr_data = 0; rx_valid = 0; rx_byte = 0; rst_n = 0;
    do_reset();

    // R1 outputs idle after reset
    check(1, "tx_valid reset", {7'd0, tx_valid}, 8'd0);
    check(1, "irq lines reset", {6'd0, irq_rx, irq_tx}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, VEC[i][19], VEC[i][18:16], VEC[i][15:8], 1'b0, 8'h00);
      if (!VEC[i][19]) check(int'(VEC[i][23:20]), $sformatf("vector %0d", i), rd_data, VEC[i][7:0]);
    end

    // R5 receive with interrupt mode off; R3 data-ready and holding
    wreg(3'd1, 8'h00);
    rx(8'h41);
    check(5, "irq_rx with mode 00", {7'd0, irq_rx}, 8'd0);
    rreg(3'd2);
    check(3, "status after arrival", rd_data, 8'hC1);
    rreg(3'd4);
    check(3, "rx holding byte", rd_data, 8'h41);

    // R5 receive interrupt pulse with mode 01
    wreg(3'd1, 8'h01);
    rx(8'h7E);
    check(5, "irq_rx with mode 01", {7'd0, irq_rx}, 8'd1);
    idle();
    check(5, "irq_rx single cycle", {7'd0, irq_rx}, 8'd0);

    // R4 rx holding read clears only data-ready
    wreg(3'd2, 8'h0E);
    rx(8'h33);
    rreg(3'd4);
    check(4, "rx holding byte", rd_data, 8'h33);
    rreg(3'd2);
    check(4, "status after rx read", rd_data, 8'h0E);

    // R6 transmit strobe and flags, R7 mode off
    wreg(3'd1, 8'h00);
    wreg(3'd2, 8'h00);
    wreg(3'd3, 8'h55);
    check(6, "tx_valid", {7'd0, tx_valid}, 8'd1);
    check(6, "tx_byte", tx_byte, 8'h55);
    check(7, "irq_tx mode 00", {7'd0, irq_tx}, 8'd0);
    idle();
    check(6, "tx_valid single cycle", {7'd0, tx_valid}, 8'd0);
    rreg(3'd2);
    check(6, "empty flags set", rd_data, 8'hC0);

    // R7 transmit interrupt modes
    wreg(3'd1, 8'h0C);
    wreg(3'd3, 8'h99);
    check(7, "irq_tx mode 11", {7'd0, irq_tx}, 8'd1);
    check(6, "tx_byte second", tx_byte, 8'h99);
    wreg(3'd1, 8'h08);
    wreg(3'd3, 8'h66);
    check(7, "irq_tx mode 10", {7'd0, irq_tx}, 8'd0);
    rreg(3'd3);
    check(9, "tx holding readback", rd_data, 8'h66);

    // R3 arrival wins over same-cycle status read
    wreg(3'd2, 8'h00);
    cyc(1'b1, 1'b0, 3'd2, 8'h00, 1'b1, 8'h10);
    check(2, "status read value", rd_data, 8'h00);
    rreg(3'd2);
    check(3, "data-ready survives read", rd_data, 8'h01);
    rreg(3'd4);
    check(3, "rx byte in collision", rd_data, 8'h10);

    // R1 mid-run reset
    wreg(3'd0, 8'h77);
    do_reset();
    rreg(3'd2);
    check(1, "status after reset", rd_data, 8'hC0);
    rreg(3'd0);
    check(1, "line setup after reset", rd_data, 8'h00);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule